// File: doc/BRIEF.md
# Multi-Byte Command Collector

This block sits behind a byte-wide host write port and turns a stream of bytes, one per strobe, into whole commands. While idle it treats the next accepted byte as an opcode. It looks the opcode up in a small parameter table to learn how many argument bytes follow. It stores those bytes in an argument buffer, in arrival order, and then raises a one-cycle ready pulse. With the pulse it presents the opcode, the number of argument bytes received and an overflow flag. A consumer reads the stored arguments through a separate index/data read port.

Commands whose length is not fixed use a two-pass collection. The first pass gathers a short header. The last header byte gives the count of payload bytes, which the second pass collects. A flag inside the collector's command state keeps it busy between the two passes. Opcodes that are not in the table are dropped, with a one-cycle error pulse. Carrying out the commands is left to the consumer.

Top module: `cmd_collector`

## Requirements
- R1: After reset the collector is idle, and ready_o, unknown_o, clipped_o, opcode_o and arg_cnt_o are all zero.
- R2: A byte accepted while idle is taken as an opcode. A zero-argument opcode (INIT 0x01, BEEP 0x05 by default) raises ready_o in the cycle after its strobe, with that opcode and an arg_cnt_o of 0. The collector stays idle.
- R3: A fixed-length opcode (CONTRAST 0x02 and LED 0x04 by default, one argument each) raises ready_o in the cycle after the strobe of its last argument. Buffer index 0 then holds that argument.
- R4: Every argument byte decrements the remaining count and is stored at the next buffer index. A byte arriving while arguments are still expected is data even if it equals an opcode value. ready_o stays low until the count reaches zero.
- R5: The variable-length DISP opcode (0x03) first collects HDR_LEN header bytes (default 2). The last header byte is an unsigned payload count N. It then collects N further bytes and raises ready_o with arg_cnt_o = HDR_LEN + N. Header and payload sit at buffer indices 0 upward, in arrival order.
- R6: A DISP header whose count byte is zero raises ready_o in the cycle after that byte, with arg_cnt_o = HDR_LEN.
- R7: ready_o is high for exactly one cycle per completed command. opcode_o, arg_cnt_o and clipped_o keep their values until the next known opcode is accepted.
- R8: Argument bytes beyond BUF_DEPTH are not stored and leave earlier buffer entries unchanged. clipped_o goes high once arg_cnt_o exceeds BUF_DEPTH, and arg_cnt_o still counts every argument byte.
- R9: An opcode missing from the table raises unknown_o for one cycle, never ready_o, and leaves the collector idle, so the next byte is again an opcode.
- R10: A byte presented while strobe_i is low is ignored, and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_i | input | 8 | Host command byte |
| strobe_i | input | 1 | Accept byte_i on this clock edge |
| rd_idx_i | input | $clog2(BUF_DEPTH) | Argument buffer read index |
| rd_data_o | output | 8 | Argument byte at rd_idx_i (combinational) |
| opcode_o | output | 8 | Opcode of the current or last completed command |
| arg_cnt_o | output | 9 | Argument bytes received for that command |
| ready_o | output | 1 | One-cycle pulse: command complete |
| unknown_o | output | 1 | One-cycle pulse: unknown opcode dropped |
| clipped_o | output | 1 | Argument bytes exceeded buffer depth |

## Verification
The assertions check several rules on every cycle. The remaining count steps down by one per argument byte. A nonzero header count reloads it and ends the extended phase. A ready pulse always follows a strobe. Unknown opcodes leave the collector idle and never coincide with ready. The overflow flag goes with an argument count above the buffer depth. Idle cycles change no state. Only the bench scenarios can show the values that reach the consumer: the buffer contents at each index after fixed, extended, zero-count and overflowing commands; the opcode and count carried by each pulse; and an opcode-valued byte being taken as data in mid-command.

// File: rtl/cmdc_pkg.sv
package cmdc_pkg;
   typedef enum logic [1:0] {
      KIND_UNKNOWN  = 2'd0,
      KIND_SINGLE   = 2'd1,
      KIND_FIXED    = 2'd2,
      KIND_EXTENDED = 2'd3
   } cmd_kind_e;

   typedef struct packed {
      cmd_kind_e  kind;
      logic [7:0] len;
   } cmd_class_t;
endpackage

// File: rtl/cmdc_decode.sv
module cmdc_decode
   import cmdc_pkg::*;
#(
   parameter logic [7:0] OP_INIT      = 8'h01,
   parameter logic [7:0] OP_CONTRAST  = 8'h02,
   parameter logic [7:0] OP_DISP      = 8'h03,
   parameter logic [7:0] OP_LED       = 8'h04,
   parameter logic [7:0] OP_BEEP      = 8'h05,
   parameter int         LEN_INIT     = 0,
   parameter int         LEN_CONTRAST = 1,
   parameter int         LEN_LED      = 1,
   parameter int         LEN_BEEP     = 0,
   parameter int         HDR_LEN      = 2
) (
   input  logic [7:0] opcode_i,
   output cmd_class_t class_o
);
   localparam int NUM_OPS = 5;
   localparam logic [7:0] OPS  [NUM_OPS] = '{OP_INIT, OP_CONTRAST, OP_DISP, OP_LED, OP_BEEP};
   localparam logic [7:0] LENS [NUM_OPS] = '{8'(LEN_INIT), 8'(LEN_CONTRAST), 8'(HDR_LEN),
                                             8'(LEN_LED), 8'(LEN_BEEP)};
   localparam logic [NUM_OPS-1:0] EXT_MASK = 5'b00100;

   if (HDR_LEN < 1 || HDR_LEN > 255) begin : g_bad_hdr
      $error("cmdc_decode: HDR_LEN must be in 1..255");
   end

   for (genvar a = 0; a < NUM_OPS; a++) begin : g_uniq_a
      for (genvar b = a + 1; b < NUM_OPS; b++) begin : g_uniq_b
         if (OPS[a] == OPS[b]) begin : g_dup
            $error("cmdc_decode: opcode table holds a duplicate value");
         end
      end
   end

   logic [NUM_OPS-1:0] hit;

   for (genvar g = 0; g < NUM_OPS; g++) begin : g_match
      assign hit[g] = (opcode_i == OPS[g]);
   end

   always_comb begin
      class_o.kind = KIND_UNKNOWN;
      class_o.len  = 8'd0;
      for (int i = 0; i < NUM_OPS; i++) begin
         if (hit[i]) begin
            class_o.len = LENS[i];
            if (EXT_MASK[i])
               class_o.kind = KIND_EXTENDED;
            else if (LENS[i] == 8'd0)
               class_o.kind = KIND_SINGLE;
            else
               class_o.kind = KIND_FIXED;
         end
      end
   end
endmodule

// File: rtl/cmdc_arg_buffer.sv
module cmdc_arg_buffer #(
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 8,
   parameter bit CLEAR_MEM = 1'b1,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("cmdc_arg_buffer: DEPTH must be in 2..256");
   end
   if ((1 << IDX_W) != DEPTH) begin : g_bad_pow2
      $error("cmdc_arg_buffer: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic sel;
      assign sel = wr_en_i && (wr_idx_i == IDX_W'(e));
      if (CLEAR_MEM) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mem[e] <= '0;
            else if (sel) mem[e] <= wr_data_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (sel) mem[e] <= wr_data_i;
         end
      end
   end

   assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/cmdc_sequencer.sv
module cmdc_sequencer
   import cmdc_pkg::*;
#(
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int TOT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_i,
   input  logic [7:0]       byte_i,
   input  cmd_class_t       class_i,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [7:0]       opcode_o,
   output logic [TOT_W-1:0] total_o,
   output logic             ready_o,
   output logic             unknown_o,
   output logic             clipped_o,
   output logic             empty_o,
   output logic             ext_o,
   output logic [7:0]       remain_o
);
   localparam logic [TOT_W-1:0] DEPTH_T = TOT_W'(DEPTH);

   logic             empty_q, ext_q, ready_q, unk_q, clip_q;
   logic [7:0]       opcode_q, remain_q;
   logic [TOT_W-1:0] total_q;
   logic             in_room;

   assign in_room  = (total_q < DEPTH_T);
   assign wr_en_o  = strobe_i && !empty_q && in_room;
   assign wr_idx_o = total_q[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q  <= 1'b1;
         ext_q    <= 1'b0;
         ready_q  <= 1'b0;
         unk_q    <= 1'b0;
         clip_q   <= 1'b0;
         opcode_q <= 8'd0;
         remain_q <= 8'd0;
         total_q  <= '0;
      end else begin
         ready_q <= 1'b0;
         unk_q   <= 1'b0;
         if (strobe_i) begin
            if (empty_q) begin
               unique case (class_i.kind)
                  KIND_UNKNOWN: unk_q <= 1'b1;
                  KIND_SINGLE: begin
                     ready_q  <= 1'b1;
                     opcode_q <= byte_i;
                     total_q  <= '0;
                     clip_q   <= 1'b0;
                  end
                  default: begin
                     opcode_q <= byte_i;
                     total_q  <= '0;
                     clip_q   <= 1'b0;
                     empty_q  <= 1'b0;
                     ext_q    <= (class_i.kind == KIND_EXTENDED);
                     remain_q <= class_i.len;
                  end
               endcase
            end else begin
               total_q <= total_q + 1'b1;
               if (!in_room) clip_q <= 1'b1;
               if (remain_q == 8'd1) begin
                  if (ext_q && byte_i != 8'd0) begin
                     ext_q    <= 1'b0;
                     remain_q <= byte_i;
                  end else begin
                     ext_q    <= 1'b0;
                     empty_q  <= 1'b1;
                     ready_q  <= 1'b1;
                     remain_q <= 8'd0;
                  end
               end else begin
                  remain_q <= remain_q - 1'b1;
               end
            end
         end
      end
   end

   assign opcode_o  = opcode_q;
   assign total_o   = total_q;
   assign ready_o   = ready_q;
   assign unknown_o = unk_q;
   assign clipped_o = clip_q;
   assign empty_o   = empty_q;
   assign ext_o     = ext_q;
   assign remain_o  = remain_q;
endmodule

// File: rtl/cmd_collector.sv
module cmd_collector
   import cmdc_pkg::*;
#(
   parameter int         BUF_DEPTH    = 16,
   parameter bit         CLEAR_MEM    = 1'b1,
   parameter logic [7:0] OP_INIT      = 8'h01,
   parameter logic [7:0] OP_CONTRAST  = 8'h02,
   parameter logic [7:0] OP_DISP      = 8'h03,
   parameter logic [7:0] OP_LED       = 8'h04,
   parameter logic [7:0] OP_BEEP      = 8'h05,
   parameter int         LEN_INIT     = 0,
   parameter int         LEN_CONTRAST = 1,
   parameter int         LEN_LED      = 1,
   parameter int         LEN_BEEP     = 0,
   parameter int         HDR_LEN      = 2,
   localparam int        IDX_W        = $clog2(BUF_DEPTH),
   localparam int        TOT_W        = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       byte_i,
   input  logic             strobe_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [7:0]       rd_data_o,
   output logic [7:0]       opcode_o,
   output logic [TOT_W-1:0] arg_cnt_o,
   output logic             ready_o,
   output logic             unknown_o,
   output logic             clipped_o
);
   cmd_class_t       cls;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic             cmd_empty, cmd_ext;
   logic [7:0]       remain;

   cmdc_decode #(
      .OP_INIT(OP_INIT), .OP_CONTRAST(OP_CONTRAST), .OP_DISP(OP_DISP),
      .OP_LED(OP_LED), .OP_BEEP(OP_BEEP), .LEN_INIT(LEN_INIT),
      .LEN_CONTRAST(LEN_CONTRAST), .LEN_LED(LEN_LED), .LEN_BEEP(LEN_BEEP),
      .HDR_LEN(HDR_LEN)
   ) i_decode (
      .opcode_i(byte_i),
      .class_o (cls)
   );

   cmdc_sequencer #(.DEPTH(BUF_DEPTH)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_i),
      .byte_i   (byte_i),
      .class_i  (cls),
      .wr_en_o  (wr_en),
      .wr_idx_o (wr_idx),
      .opcode_o (opcode_o),
      .total_o  (arg_cnt_o),
      .ready_o  (ready_o),
      .unknown_o(unknown_o),
      .clipped_o(clipped_o),
      .empty_o  (cmd_empty),
      .ext_o    (cmd_ext),
      .remain_o (remain)
   );

   cmdc_arg_buffer #(.DEPTH(BUF_DEPTH), .DATA_W(8), .CLEAR_MEM(CLEAR_MEM)) i_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en),
      .wr_idx_i (wr_idx),
      .wr_data_i(byte_i),
      .rd_idx_i (rd_idx_i),
      .rd_data_o(rd_data_o)
   );
endmodule

// File: rtl/cmd_collector_chk.sv
module cmd_collector_chk #(
   parameter int BUF_DEPTH = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] byte_i,
   input logic       strobe_i,
   input logic [8:0] arg_cnt_o,
   input logic       ready_o,
   input logic       unknown_o,
   input logic       clipped_o,
   input logic       cmd_empty,
   input logic       cmd_ext,
   input logic [7:0] remain
);
   localparam logic [8:0] DEPTH_T = 9'(BUF_DEPTH);

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !cmd_empty && remain > 8'd1) |=> (remain == $past(remain) - 8'd1));

   p_ext_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !cmd_empty && cmd_ext && remain == 8'd1 && byte_i != 8'd0)
      |=> (!cmd_empty && !cmd_ext && remain == $past(byte_i) && !ready_o));

   p_ready_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> $past(strobe_i));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clipped_o == (arg_cnt_o > DEPTH_T));

   p_unknown_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      unknown_o |-> (cmd_empty && !ready_o));

   p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |=> ($stable(remain) && $stable(cmd_empty) && $stable(arg_cnt_o)
                     && !ready_o && !unknown_o));
endmodule

bind cmd_collector cmd_collector_chk #(.BUF_DEPTH(BUF_DEPTH)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .byte_i   (byte_i),
   .strobe_i (strobe_i),
   .arg_cnt_o(arg_cnt_o),
   .ready_o  (ready_o),
   .unknown_o(unknown_o),
   .clipped_o(clipped_o),
   .cmd_empty(cmd_empty),
   .cmd_ext  (cmd_ext),
   .remain   (remain)
);

// File: tb/test_cmd_collector.sv
`timescale 1ns/1ps
module test_cmd_collector;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] byte_i;
   logic       strobe_i;
   logic [3:0] rd_idx;
   logic [7:0] rd_data;
   logic [7:0] opcode;
   logic [8:0] arg_cnt;
   logic       ready, unknown, clipped;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   cmd_collector i_cmd_collector (
      .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .strobe_i(strobe_i),
      .rd_idx_i(rd_idx), .rd_data_o(rd_data), .opcode_o(opcode),
      .arg_cnt_o(arg_cnt), .ready_o(ready), .unknown_o(unknown), .clipped_o(clipped)
   );

   // {byte, exp_ready, exp_unknown, exp_cnt[9], exp_opcode}
   localparam int NV = 16;
   localparam logic [26:0] VEC [NV] = '{
      {8'h05, 1'b1, 1'b0, 9'd0, 8'h05},   // R2 beep
      {8'h01, 1'b1, 1'b0, 9'd0, 8'h01},   // R2 init
      {8'h02, 1'b0, 1'b0, 9'd0, 8'h00},   // R3 contrast opcode
      {8'hAB, 1'b1, 1'b0, 9'd1, 8'h02},   // R3 contrast arg
      {8'h04, 1'b0, 1'b0, 9'd0, 8'h00},   // R4 led opcode
      {8'h05, 1'b1, 1'b0, 9'd1, 8'h04},   // R4 opcode-valued data byte
      {8'h7E, 1'b0, 1'b1, 9'd0, 8'h00},   // R9 unknown
      {8'h03, 1'b0, 1'b0, 9'd0, 8'h00},   // R6 disp
      {8'h00, 1'b0, 1'b0, 9'd0, 8'h00},
      {8'h00, 1'b1, 1'b0, 9'd2, 8'h03},   // R6 zero count
      {8'h03, 1'b0, 1'b0, 9'd0, 8'h00},   // R5 disp
      {8'h80, 1'b0, 1'b0, 9'd0, 8'h00},
      {8'h03, 1'b0, 1'b0, 9'd0, 8'h00},
      {8'h41, 1'b0, 1'b0, 9'd0, 8'h00},
      {8'h42, 1'b0, 1'b0, 9'd0, 8'h00},
      {8'h43, 1'b1, 1'b0, 9'd5, 8'h03}    // R5 complete
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      byte_i   = b;
      strobe_i = 1'b1;
      @(negedge clk);
      strobe_i = 1'b0;
   endtask

   task automatic read_at(input int idx, output logic [7:0] val);
      rd_idx = 4'(idx);
      #0.5;
      val = rd_data;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      rst_n = 1'b0; strobe_i = 1'b0; byte_i = 8'h00; rd_idx = 4'd0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ready", int'(ready), 0);
      check("R1 unknown", int'(unknown), 0);
      check("R1 clipped", int'(clipped), 0);
      check("R1 opcode", int'(opcode), 0);
      check("R1 arg_cnt", int'(arg_cnt), 0);
      rst_n = 1'b1;

      // R10 byte without strobe ignored
      byte_i = 8'h05;
      repeat (3) @(negedge clk);
      check("R10 ready", int'(ready), 0);
      check("R10 opcode", int'(opcode), 0);
      send(8'hAA);   // idle: unknown opcode, then still idle
      check("R10 unknown on strobe", int'(unknown), 1);

      for (int i = 0; i < NV; i++) begin
         send(VEC[i][26:19]);
         check($sformatf("vec%0d ready", i), int'(ready), int'(VEC[i][18]));
         check($sformatf("vec%0d unknown", i), int'(unknown), int'(VEC[i][17]));
         if (VEC[i][18]) begin
            check($sformatf("vec%0d arg_cnt", i), int'(arg_cnt), int'(VEC[i][16:8]));
            check($sformatf("vec%0d opcode", i), int'(opcode), int'(VEC[i][7:0]));
         end
      end

      // R5 buffer contents of the extended command
      check("R5 clipped", int'(clipped), 0);
      read_at(0, v); check("R5 idx0", int'(v), 'h80);
      read_at(1, v); check("R5 idx1", int'(v), 'h03);
      read_at(2, v); check("R5 idx2", int'(v), 'h41);
      read_at(4, v); check("R5 idx4", int'(v), 'h43);

      // R7 pulse width and held values
      @(negedge clk);
      check("R7 ready low", int'(ready), 0);
      check("R7 opcode held", int'(opcode), 'h03);
      check("R7 cnt held", int'(arg_cnt), 5);

      // R3 fixed-length argument in buffer
      send(8'h04);
      send(8'h3C);
      check("R3 ready", int'(ready), 1);
      read_at(0, v); check("R3 idx0", int'(v), 'h3C);

      // R8 overflow: header count 20, total 22 > 16
      send(8'h03);
      send(8'h00);
      send(8'h14);
      for (int k = 0; k < 20; k++) begin
         send(8'(8'h60 + k));
         if (k == 18) check("R4 not ready early", int'(ready), 0);
      end
      check("R8 ready", int'(ready), 1);
      check("R8 arg_cnt", int'(arg_cnt), 22);
      check("R8 clipped", int'(clipped), 1);
      read_at(1, v);  check("R8 idx1", int'(v), 'h14);
      read_at(2, v);  check("R8 idx2", int'(v), 'h60);
      read_at(15, v); check("R8 idx15", int'(v), 'h6D);

      // R9 unknown keeps idle; next byte is an opcode
      send(8'hF0);
      check("R9 unknown", int'(unknown), 1);
      check("R9 no ready", int'(ready), 0);
      check("R9 opcode kept", int'(opcode), 'h03);
      send(8'h05);
      check("R9 next opcode ready", int'(ready), 1);
      check("R2 beep cnt", int'(arg_cnt), 0);
      check("R8 clipped cleared", int'(clipped), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule